// File: doc/BRIEF.md
# DMA Cascade Bus-Master Bridge

This block lets a network controller with a simple HOLD/HLDA bus request become master of an ISA-style host bus. When the controller raises its hold request, the bridge drives one of four DMA request lines, chosen by a configuration field. The host's DMA controller, set to cascade mode, answers on the matching acknowledge line. The bridge then claims bus mastership and grants the bus to the controller.

While it owns the bus, the bridge runs the controller's memory transfers. It latches the transfer address on the controller's address strobe and opens the address and data buffers. It sets the data direction and pulses the memory read or write strobe for a programmable number of cycles. It returns ready to the controller only once the host has signalled ready.

Two timers bound the ownership. A hold timer can pre-empt the controller after a fixed time. A grace timer lets a short drop in HOLD pass without giving up the DMA channel. Channel, speed, pre-emption and write setup extension are held as static configuration while the bus is owned.

Top module: `dma_cascade_master`

## Requirements
- R1: While reset is asserted, and right after it, every `drq` bit is 0, `ctl_hlda` is 0, `master_n`, `memr_n` and `memw_n` are 1, and `addr_oe`, `data_oe` and `ctl_rdy` are 0.
- R2: One cycle after `ctl_hold` is sampled high, `drq` equals 1 shifted left by `cfg_chan_sel` (value n selects line n), with all other bits 0. Only `dack_n[cfg_chan_sel]` (active low) is honoured.
- R3: One cycle after the selected acknowledge is sampled low, `master_n` goes low while `ctl_hlda` stays low. One cycle later `ctl_hlda` goes high. `ctl_hlda` is never high while `master_n` is high.
- R4: With `cfg_preempt_en` = 1 and HOLD kept high, `ctl_hlda` stays high for exactly HOLD_CYC cycles and then falls, and `drq` drops in the same cycle. With `cfg_preempt_en` = 0, a granted HOLD that stays high keeps `ctl_hlda` high indefinitely.
- R5: If HOLD drops while fewer than GRACE_CYC cycles have passed since the acknowledge, `ctl_hlda` falls one cycle later while `drq` stays asserted. When HOLD rises again, `ctl_hlda` returns one cycle later.
- R6: If HOLD drops after GRACE_CYC cycles of ownership, `drq` and `ctl_hlda` are both 0 one cycle later.
- R7: One cycle after the selected acknowledge is withdrawn, `master_n`, `memr_n` and `memw_n` are 1 and `addr_oe` and `data_oe` are 0, even in the middle of a transfer.
- R8: A transfer starts when `ctl_as` is sampled high while `ctl_hlda` is high. `host_addr` takes `ctl_addr` and keeps it. `addr_oe` and `data_oe` are high from the next cycle through the ready cycle. `data_dir` is 1 for a write (`ctl_wr` = 1) and 0 for a read.
- R9: A write drives only `memw_n` low and a read drives only `memr_n` low. With the host ready, the strobe lasts STRB_W0, STRB_W1, STRB_W2 or STRB_W3 cycles for `cfg_speed` 0, 1, 2 or 3.
- R10: While `host_rdy` is low the strobe is stretched, so it lasts the larger of its nominal width and the cycle in which ready is seen. `ctl_rdy` is high for exactly one cycle, right after the strobe ends, and only after `host_rdy` was sampled high.
- R11: With `cfg_wr_setup_ext` = 1, a write has one cycle with buffers open before `memw_n` falls. Reads, and writes with the bit at 0, start their strobe in the first cycle after the address strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chan_sel | input | 2 | DMA channel pair select |
| cfg_preempt_en | input | 1 | Enables pre-emption by the hold timer |
| cfg_speed | input | 2 | Strobe width select |
| cfg_wr_setup_ext | input | 1 | Adds one setup cycle before write strobes |
| ctl_hold | input | 1 | Bus request from the controller |
| ctl_hlda | output | 1 | Bus grant to the controller |
| ctl_as | input | 1 | Controller address strobe |
| ctl_wr | input | 1 | 1 = memory write, 0 = memory read |
| ctl_addr | input | AW | Controller transfer address |
| ctl_rdy | output | 1 | Transfer complete pulse to the controller |
| drq | output | 4 | DMA request lines, active high |
| dack_n | input | 4 | DMA acknowledge lines, active low |
| master_n | output | 1 | Bus mastership claim, active low |
| host_addr | output | AW | Latched address towards the address buffers |
| addr_oe | output | 1 | Address buffer enable |
| data_oe | output | 1 | Data buffer enable |
| data_dir | output | 1 | Data buffer direction, 1 = towards memory |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| host_rdy | input | 1 | Host ready, high = cycle may finish |

## Verification
The properties take the configuration inputs as stable whenever the selected acknowledge is low. They also assume the DMA controller asserts acknowledge only on the channel whose request is active. The stimulus changes `cfg_chan_sel`, `cfg_preempt_en`, `cfg_speed` and `cfg_wr_setup_ext` only while all acknowledges are high. It drives acknowledge only on the line it just saw requested, and pulses `ctl_as` only while the grant is high. Host ready is held low only for a bounded number of strobe cycles, except in the abort case, where the acknowledge is withdrawn instead.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  typedef enum logic [2:0] {
    ARB_IDLE,
    ARB_REQ,
    ARB_MSTR,
    ARB_OWN,
    ARB_GRACE,
    ARB_REL
  } arb_state_t;

  typedef enum logic [1:0] {
    XF_IDLE,
    XF_SETUP,
    XF_STRB,
    XF_RDY
  } xfer_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dmab_arbiter.sv
module dmab_arbiter
  import dmab_pkg::*;
#(
  parameter int CH        = 4,
  parameter int SELW      = 2,
  parameter int HOLD_CYC  = 40,
  parameter int GRACE_CYC = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] chan_sel,
  input  logic            preempt_en,
  input  logic            hold,
  input  logic [CH-1:0]   dack_n,
  output logic [CH-1:0]   drq,
  output logic            hlda,
  output logic            master,
  output logic            keep
);

  localparam int CNT_MAX = max2(HOLD_CYC, GRACE_CYC);
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_L  = CW'(HOLD_CYC);
  localparam logic [CW-1:0] GRACE_L = CW'(GRACE_CYC);
  localparam logic [CW-1:0] MAX_L   = CW'(CNT_MAX);

  arb_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          req_q, req_d;
  logic          hlda_q, hlda_d;
  logic          mst_q, mst_d;
  logic          dack_sel, hold_exp, grace_exp;

  assign dack_sel  = ~dack_n[chan_sel];
  assign hold_exp  = (cnt_q >= HOLD_L);
  assign grace_exp = (cnt_q >= GRACE_L);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ARB_IDLE:  if (hold) st_d = ARB_REQ;
      ARB_REQ: begin
        if (!hold)         st_d = ARB_IDLE;
        else if (dack_sel) st_d = ARB_MSTR;
      end
      ARB_MSTR:  st_d = dack_sel ? ARB_OWN : ARB_IDLE;
      ARB_OWN: begin
        if (!dack_sel)                  st_d = ARB_IDLE;
        else if (preempt_en && hold_exp) st_d = ARB_REL;
        else if (!hold)                 st_d = grace_exp ? ARB_REL : ARB_GRACE;
      end
      ARB_GRACE: begin
        if (!dack_sel)                  st_d = ARB_IDLE;
        else if (preempt_en && hold_exp) st_d = ARB_REL;
        else if (hold)                  st_d = ARB_OWN;
        else if (grace_exp)             st_d = ARB_REL;
      end
      ARB_REL:   if (!dack_sel) st_d = ARB_IDLE;
      default:   st_d = ARB_IDLE;
    endcase
  end

  always_comb begin
    cnt_en = (st_q != ARB_IDLE);
    if (st_q == ARB_REQ)     cnt_d = '0;
    else if (cnt_q < MAX_L)  cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_comb begin
    mst_d  = (st_d == ARB_MSTR) || (st_d == ARB_OWN) ||
             (st_d == ARB_GRACE) || (st_d == ARB_REL);
    hlda_d = (st_d == ARB_OWN);
    req_d  = (st_d == ARB_REQ) || (st_d == ARB_MSTR) ||
             (st_d == ARB_OWN) || (st_d == ARB_GRACE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ARB_IDLE;
      req_q  <= 1'b0;
      hlda_q <= 1'b0;
      mst_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      req_q  <= req_d;
      hlda_q <= hlda_d;
      mst_q  <= mst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < CH; i++) begin : g_drq
    assign drq[i] = req_q && (chan_sel == SELW'(i));
  end

  assign hlda   = hlda_q;
  assign master = mst_q;
  assign keep   = mst_q & dack_sel;

endmodule

// File: rtl/dmab_xfer.sv
module dmab_xfer
  import dmab_pkg::*;
#(
  parameter int AW      = 24,
  parameter int STRB_W0 = 2,
  parameter int STRB_W1 = 3,
  parameter int STRB_W2 = 4,
  parameter int STRB_W3 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic          keep,
  input  logic          as,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    speed,
  input  logic          wr_ext,
  input  logic          host_rdy,
  output logic [AW-1:0] host_addr,
  output logic          addr_oe,
  output logic          data_oe,
  output logic          data_dir,
  output logic          memr,
  output logic          memw,
  output logic          ctl_rdy
);

  localparam int WMAX = max2(max2(STRB_W0, STRB_W1), max2(STRB_W2, STRB_W3));
  localparam int CW   = $clog2(WMAX + 1);

  xfer_state_t   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] wlast;
  logic          start, cap_en;
  logic [AW-1:0] addr_q;
  logic          dir_q, dir_d;
  logic          busy_q, strr_q, strw_q, rdy_q;
  logic          busy_d, strr_d, strw_d, rdy_d;

  always_comb begin
    case (speed)
      2'd0:    wlast = CW'(STRB_W0 - 1);
      2'd1:    wlast = CW'(STRB_W1 - 1);
      2'd2:    wlast = CW'(STRB_W2 - 1);
      default: wlast = CW'(STRB_W3 - 1);
    endcase
  end

  assign start  = (st_q == XF_IDLE) && as && grant && keep;
  assign cap_en = start;

  always_comb begin
    st_d = st_q;
    if (!keep) begin
      st_d = XF_IDLE;
    end else begin
      case (st_q)
        XF_IDLE:  if (start) st_d = (wr && wr_ext) ? XF_SETUP : XF_STRB;
        XF_SETUP: st_d = XF_STRB;
        XF_STRB:  if ((cnt_q >= wlast) && host_rdy) st_d = XF_RDY;
        XF_RDY:   st_d = XF_IDLE;
        default:  st_d = XF_IDLE;
      endcase
    end
  end

  always_comb begin
    if (st_q != XF_STRB)      cnt_d = '0;
    else if (cnt_q < wlast)   cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
    dir_d  = start ? wr : dir_q;
    busy_d = (st_d != XF_IDLE);
    strw_d = (st_d == XF_STRB) && dir_d;
    strr_d = (st_d == XF_STRB) && !dir_d;
    rdy_d  = (st_d == XF_RDY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XF_IDLE;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
      strr_q <= 1'b0;
      strw_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      busy_q <= busy_d;
      strr_q <= strr_d;
      strw_q <= strw_d;
      rdy_q  <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (cap_en) addr_q <= addr;
  end

  assign host_addr = addr_q;
  assign addr_oe   = busy_q;
  assign data_oe   = busy_q;
  assign data_dir  = dir_q;
  assign memr      = strr_q;
  assign memw      = strw_q;
  assign ctl_rdy   = rdy_q;

endmodule

// File: rtl/dma_cascade_master.sv
module dma_cascade_master #(
  parameter int AW        = 24,
  parameter int HOLD_CYC  = 40,
  parameter int GRACE_CYC = 12,
  parameter int STRB_W0   = 2,
  parameter int STRB_W1   = 3,
  parameter int STRB_W2   = 4,
  parameter int STRB_W3   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_chan_sel,
  input  logic          cfg_preempt_en,
  input  logic [1:0]    cfg_speed,
  input  logic          cfg_wr_setup_ext,
  input  logic          ctl_hold,
  output logic          ctl_hlda,
  input  logic          ctl_as,
  input  logic          ctl_wr,
  input  logic [AW-1:0] ctl_addr,
  output logic          ctl_rdy,
  output logic [3:0]    drq,
  input  logic [3:0]    dack_n,
  output logic          master_n,
  output logic [AW-1:0] host_addr,
  output logic          addr_oe,
  output logic          data_oe,
  output logic          data_dir,
  output logic          memr_n,
  output logic          memw_n,
  input  logic          host_rdy
);

  logic hlda, master, keep, memr, memw;

  dmab_arbiter #(
    .CH(4), .SELW(2), .HOLD_CYC(HOLD_CYC), .GRACE_CYC(GRACE_CYC)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .chan_sel(cfg_chan_sel),
    .preempt_en(cfg_preempt_en), .hold(ctl_hold), .dack_n(dack_n),
    .drq(drq), .hlda(hlda), .master(master), .keep(keep)
  );

  dmab_xfer #(
    .AW(AW), .STRB_W0(STRB_W0), .STRB_W1(STRB_W1),
    .STRB_W2(STRB_W2), .STRB_W3(STRB_W3)
  ) u_xfer (
    .clk(clk), .rst_n(rst_n), .grant(hlda), .keep(keep),
    .as(ctl_as), .wr(ctl_wr), .addr(ctl_addr), .speed(cfg_speed),
    .wr_ext(cfg_wr_setup_ext), .host_rdy(host_rdy),
    .host_addr(host_addr), .addr_oe(addr_oe), .data_oe(data_oe),
    .data_dir(data_dir), .memr(memr), .memw(memw), .ctl_rdy(ctl_rdy)
  );

  assign ctl_hlda = hlda;
  assign master_n = ~master;
  assign memr_n   = ~memr;
  assign memw_n   = ~memw;

endmodule

// File: rtl/dma_cascade_master_chk.sv
module dma_cascade_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_chan_sel,
  input logic       cfg_preempt_en,
  input logic       ctl_hold,
  input logic       ctl_hlda,
  input logic       ctl_rdy,
  input logic [3:0] drq,
  input logic [3:0] dack_n,
  input logic       master_n,
  input logic       addr_oe,
  input logic       data_oe,
  input logic       data_dir,
  input logic       memr_n,
  input logic       memw_n,
  input logic       host_rdy
);

  assert_drq_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drq));

  assert_grant_needs_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hlda |-> !master_n);

  assert_master_before_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_hlda) |-> $past(!master_n));

  assert_hold_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hlda && ctl_hold && !cfg_preempt_en && !dack_n[cfg_chan_sel]) |=> ctl_hlda);

  assert_grant_follows_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hlda && !ctl_hold) |=> !ctl_hlda);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_n && dack_n[cfg_chan_sel]) |=> (master_n && memr_n && memw_n && !addr_oe && !data_oe));

  assert_buffers_in_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdy |-> (addr_oe && data_oe));

  assert_write_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !memw_n |-> (data_dir && addr_oe));

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!memr_n && !memw_n));

  assert_rdy_after_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdy |-> $past(host_rdy));

  assert_rdy_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdy |=> !ctl_rdy);

endmodule

bind dma_cascade_master dma_cascade_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_chan_sel(cfg_chan_sel),
  .cfg_preempt_en(cfg_preempt_en), .ctl_hold(ctl_hold), .ctl_hlda(ctl_hlda),
  .ctl_rdy(ctl_rdy), .drq(drq), .dack_n(dack_n), .master_n(master_n),
  .addr_oe(addr_oe), .data_oe(data_oe), .data_dir(data_dir),
  .memr_n(memr_n), .memw_n(memw_n), .host_rdy(host_rdy)
);

// File: tb/dma_cascade_master_tb_top.sv
module dma_cascade_master_tb_top;

  localparam int AW    = 24;
  localparam int HOLDC = 40;
  localparam int GRACC = 12;
  localparam int W0 = 2, W1 = 3, W2 = 4, W3 = 6;
  localparam int NV = 8;
  // vector: wr[31] speed[30:29] ext[28] stall[27:24] addr[23:0]
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b0, 4'd0, 24'h0C4000},
    {1'b0, 2'd1, 1'b0, 4'd0, 24'h123456},
    {1'b1, 2'd2, 1'b1, 4'd0, 24'hABCDEF},
    {1'b0, 2'd3, 1'b1, 4'd0, 24'h000001},
    {1'b1, 2'd3, 1'b0, 4'd9, 24'hFFFFFE},
    {1'b0, 2'd0, 1'b0, 4'd5, 24'h5A5A5A},
    {1'b1, 2'd1, 1'b1, 4'd2, 24'h0F0F0F},
    {1'b0, 2'd2, 1'b0, 4'd7, 24'h800000}
  };

  logic          clk, rst_n;
  logic [1:0]    cfg_chan_sel, cfg_speed;
  logic          cfg_preempt_en, cfg_wr_setup_ext;
  logic          ctl_hold, ctl_hlda, ctl_as, ctl_wr, ctl_rdy;
  logic [AW-1:0] ctl_addr, host_addr;
  logic [3:0]    drq, dack_n;
  logic          master_n, addr_oe, data_oe, data_dir, memr_n, memw_n, host_rdy;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  dma_cascade_master #(
    .AW(AW), .HOLD_CYC(HOLDC), .GRACE_CYC(GRACC),
    .STRB_W0(W0), .STRB_W1(W1), .STRB_W2(W2), .STRB_W3(W3)
  ) dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int wid(input logic [1:0] s);
    case (s)
      2'd0: return W0;
      2'd1: return W1;
      2'd2: return W2;
      default: return W3;
    endcase
  endfunction

  task automatic acquire(input int ch);
    @(negedge clk);
    cfg_chan_sel = 2'(ch);
    ctl_hold = 1'b1;
    @(negedge clk);
    chk(drq == 4'(1 << ch), "R2 drq line", drq, 4'(1 << ch));
    dack_n = ~(4'(1 << ch));
    @(negedge clk);
    chk(!master_n && !ctl_hlda, "R3 master first", {master_n, ctl_hlda}, 2'b00);
    @(negedge clk);
    chk(ctl_hlda, "R3 grant next", ctl_hlda, 1);
  endtask

  task automatic release_all();
    @(negedge clk);
    ctl_hold = 1'b0;
    dack_n   = 4'hF;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_chan_sel = 2'd0; cfg_speed = 2'd0;
    cfg_preempt_en = 1'b0; cfg_wr_setup_ext = 1'b0;
    ctl_hold = 1'b0; ctl_as = 1'b0; ctl_wr = 1'b0; ctl_addr = '0;
    dack_n = 4'hF; host_rdy = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    chk(drq == 0 && !ctl_hlda && master_n && memr_n && memw_n && !addr_oe && !data_oe && !ctl_rdy,
        "R1 reset outputs", {drq, ctl_hlda, master_n, memr_n, memw_n, addr_oe, ctl_rdy}, 10'b0000_0_1_1_1_0_0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drq == 0 && !ctl_hlda && master_n, "R1 after release", {drq, ctl_hlda, master_n}, 6'b0000_0_1);

    // table of transfers on channel 2
    acquire(2);
    for (int v = 0; v < NV; v++) begin
      logic        vwr, vext;
      logic [1:0]  vspd;
      int          vstall, first, last, rdyi, rdyn, wrong, badoe, nstr, expw;
      logic        dirseen;
      vwr = VEC[v][31]; vspd = VEC[v][30:29]; vext = VEC[v][28];
      vstall = int'(VEC[v][27:24]);
      first = -1; last = -1; rdyi = -1; rdyn = 0; wrong = 0; badoe = 0; nstr = 0;
      dirseen = 1'b0;
      cfg_speed = vspd; cfg_wr_setup_ext = vext;
      host_rdy = (vstall == 0);
      @(negedge clk);
      ctl_as = 1'b1; ctl_wr = vwr; ctl_addr = VEC[v][23:0];
      @(negedge clk);
      ctl_as = 1'b0; ctl_addr = '0;
      for (int i = 0; i < 40; i++) begin
        logic s_ok, s_bad;
        s_ok  = vwr ? !memw_n : !memr_n;
        s_bad = vwr ? !memr_n : !memw_n;
        if (s_bad) wrong++;
        if (s_ok) begin
          if (first < 0) first = i;
          last = i; nstr++;
          dirseen = data_dir;
          if (!addr_oe || !data_oe) badoe++;
          if (nstr == vstall) host_rdy = 1'b1;
        end
        if (ctl_rdy) begin rdyn++; rdyi = i; if (!addr_oe) badoe++; end
        if (i == 0 && !addr_oe) badoe++;
        @(negedge clk);
      end
      host_rdy = 1'b1;
      expw = (vstall > wid(vspd)) ? vstall : wid(vspd);
      chk(wrong == 0 && nstr > 0, "R9 strobe select", wrong, 0);
      chk(nstr == expw && last - first + 1 == expw, "R9/R10 strobe width", nstr, expw);
      chk(first == ((vwr && vext) ? 1 : 0), "R11 strobe lead", first, (vwr && vext) ? 1 : 0);
      chk(rdyn == 1 && rdyi == last + 1, "R10 ready pulse", rdyi, last + 1);
      chk(dirseen == vwr, "R8 direction", dirseen, vwr);
      chk(host_addr == VEC[v][23:0], "R8 address latch", host_addr, VEC[v][23:0]);
      chk(badoe == 0, "R8 buffer enables", badoe, 0);
    end
    release_all();

    // R4: pre-emption after HOLDC grant cycles on channel 1
    cfg_preempt_en = 1'b1;
    acquire(1);
    begin
      int n = 1;
      for (int i = 0; i < 200 && ctl_hlda; i++) begin
        @(negedge clk);
        if (ctl_hlda) n++;
      end
      chk(n == HOLDC, "R4 preempt grant length", n, HOLDC);
      chk(drq == 0 && !master_n, "R4 drq dropped on preempt", {drq, master_n}, 5'b0000_0);
    end
    @(negedge clk);
    dack_n = 4'hF;
    @(negedge clk);
    chk(master_n, "R7 master released", master_n, 1);
    release_all();

    // R5/R6 grace window, with pre-emption off (R4), channel 3
    cfg_preempt_en = 1'b0;
    acquire(3);
    @(negedge clk);
    ctl_hold = 1'b0;
    @(negedge clk);
    chk(!ctl_hlda && drq == 4'b1000, "R5 drq kept in grace", {ctl_hlda, drq}, 5'b0_1000);
    ctl_hold = 1'b1;
    @(negedge clk);
    chk(ctl_hlda, "R5 grant returns", ctl_hlda, 1);
    repeat (50) @(negedge clk);
    chk(ctl_hlda && drq == 4'b1000, "R4 no preempt when disabled", {ctl_hlda, drq}, 5'b1_1000);
    ctl_hold = 1'b0;
    @(negedge clk);
    chk(!ctl_hlda && drq == 0 && !master_n, "R6 release after grace", {ctl_hlda, drq, master_n}, 6'b0_0000_0);
    dack_n = 4'hF;
    @(negedge clk);
    chk(master_n, "R7 master after dack", master_n, 1);
    release_all();

    // R7: acknowledge withdrawn during a stalled read, channel 0
    acquire(0);
    cfg_speed = 2'd0;
    host_rdy = 1'b0;
    @(negedge clk);
    ctl_as = 1'b1; ctl_wr = 1'b0; ctl_addr = 24'h0000AA;
    @(negedge clk);
    ctl_as = 1'b0;
    @(negedge clk);
    chk(!memr_n && addr_oe, "R10 stalled strobe held", {memr_n, addr_oe}, 2'b01);
    dack_n = 4'hF;
    @(negedge clk);
    chk(master_n && memr_n && memw_n && !addr_oe && !data_oe, "R7 abort release",
        {master_n, memr_n, memw_n, addr_oe, data_oe}, 5'b11100);
    chk(!ctl_rdy, "R10 no ready without host", ctl_rdy, 0);
    host_rdy = 1'b1;
    release_all();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule